// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline Core with Branch Flush

This block is a small in-order processor core built as four segments: instruction fetch, decode with address formation, operand fetch, and execute with register write-back. In steady state four different instructions occupy the four segments at once. The core runs a tiny instruction set with five operations: load-immediate, add-from-memory, store, unconditional jump and halt. Its instruction memory, data memory and register file are held inside the block.

The memories are filled through load ports while reset is held low. Execution begins at address 0 once reset is released. When a jump is decoded, fetching stops. The jump then travels to the execute segment, where it discards the younger instruction waiting in fetch and loads the program counter with its target. This yields a fixed gap of three empty execute cycles. Sometimes an operand-fetch instruction needs a register or a memory word that the instruction in execute is writing in the same cycle. In that case operand fetch and everything behind it wait for one cycle. A halt stops fetching and lets the pipe drain. After that, the registers and data memory can be read through combinational observation ports.

Top module: `pipe4_core`

## Requirements
- R1: While reset is low and after its release, retire_valid and halted are 0, every register reads 0 and fetching starts at address 0.
- R2: An instruction word is 16 bits: opcode in [15:12], register number in [11:8], address or immediate in [7:0]. Opcode 1 is load-immediate, 2 is add-from-memory, 3 is store, 4 is jump, 15 is halt, and every other opcode does nothing.
- R3: Load-immediate writes the 8-bit immediate to the register. Add-from-memory writes register plus data word at the address, modulo 256. Store writes the register to the data word at the address.
- R4: Without jumps or conflicts, address 0 is in execute (retire_valid high, retire_pc 0) after the third rising edge following reset release, and the following instructions then reach execute in consecutive cycles.
- R5: After a jump leaves execute, retire_valid stays low for exactly three cycles and the jump target is the next instruction to reach execute. The instruction after the jump never executes.
- R6: Instructions that precede a jump in program order complete normally.
- R7: An add-from-memory or store in operand fetch whose register is written by the instruction in execute waits one cycle, which leaves one empty execute cycle. It then uses the new register value.
- R8: An add-from-memory in operand fetch whose address matches a store in execute waits one cycle and then reads the stored value.
- R9: When a halt reaches execute, halted rises and stays high. No later instruction reaches execute, and instructions after the halt have no effect.
- R10: Writes on the data-memory load port while reset is high are ignored.
- R11: When a conflict wait lands while a jump sits in decode, the jump is held with it and keeps its three-cycle gap, and the instruction after it still never executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; memory load window |
| imem_we | input | 1 | Instruction memory load strobe (honored in reset) |
| imem_addr | input | 8 | Instruction memory load address |
| imem_wdata | input | 16 | Instruction word to load |
| dmem_we | input | 1 | Data memory load strobe (honored in reset) |
| dmem_addr | input | 8 | Data memory load and observation address |
| dmem_wdata | input | 8 | Data word to load |
| dmem_rdata | output | 8 | Data word at dmem_addr, combinational |
| reg_sel | input | 4 | Register number to observe |
| reg_rdata | output | 8 | Contents of register reg_sel, combinational |
| halted | output | 1 | A halt has completed execute |
| retire_valid | output | 1 | An instruction occupies execute this cycle |
| retire_pc | output | 8 | Address of the instruction in execute |

## Verification
The two mechanisms that can act in the same cycle are the one-cycle conflict wait and the jump hold in fetch. They meet when a store waits on a load-immediate to the same register while a jump is being decoded right behind it. A directed program sets up exactly that case. The test is judged on the execute trace, which must show one empty cycle, then the store, then the jump, three empty cycles and the target. It is also judged on the register and memory contents, which must show the instruction after the jump never ran.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

    localparam int unsigned IW   = 16;
    localparam int unsigned OPW  = 4;
    localparam int unsigned NREG = 16;
    localparam int unsigned RIDW = $clog2(NREG);
    localparam int unsigned AW   = IW - OPW - RIDW;
    localparam int unsigned DW   = 8;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'h0,
        OP_LDI  = 4'h1,
        OP_ADDM = 4'h2,
        OP_STO  = 4'h3,
        OP_BRA  = 4'h4,
        OP_HALT = 4'hF
    } op_e;

    typedef struct packed {
        logic            v;
        logic [AW-1:0]   pc;
        logic [IW-1:0]   ir;
    } fslot_t;

    typedef struct packed {
        logic            v;
        logic [AW-1:0]   pc;
        op_e             op;
        logic [RIDW-1:0] rd;
        logic [AW-1:0]   ad;
    } dslot_t;

    typedef struct packed {
        logic            v;
        logic [AW-1:0]   pc;
        op_e             op;
        logic [RIDW-1:0] rd;
        logic [AW-1:0]   ad;
        logic [DW-1:0]   rv;
        logic [DW-1:0]   mv;
    } oslot_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        fslot_t        f;
        dslot_t        d;
        oslot_t        o;
        logic          halt_seen;
        logic          halted;
    } core_st_t;

    function automatic op_e decode_op(input logic [OPW-1:0] code);
        case (code)
            4'h1:    return OP_LDI;
            4'h2:    return OP_ADDM;
            4'h3:    return OP_STO;
            4'h4:    return OP_BRA;
            4'hF:    return OP_HALT;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic logic reads_reg(input op_e op);
        return (op == OP_ADDM) || (op == OP_STO);
    endfunction

    function automatic logic writes_reg(input op_e op);
        return (op == OP_LDI) || (op == OP_ADDM);
    endfunction

endpackage

// File: rtl/pipe4_imem.sv
module pipe4_imem #(
    parameter int unsigned AW = 8,
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R2: a loaded word is returned unchanged
    a_r2_imem_load: assert property (@(posedge clk)
        (we && !rst_n) |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe4_dmem.sv
module pipe4_dmem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

    // R3: a store lands at its address
    a_r3_dmem_store: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wsel,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] ra_sel,
    output logic [DW-1:0]           ra_data,
    input  logic [$clog2(NREG)-1:0] rb_sel,
    output logic [DW-1:0]           rb_data
);
    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[wsel] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign ra_data = regs_q[ra_sel];
    assign rb_data = regs_q[rb_sel];

    // R3: register write-back takes effect on the next cycle
    a_r3_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(wsel)] == $past(wdata));

endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
    import pipe4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_we,
    input  logic [AW-1:0]   imem_addr,
    input  logic [IW-1:0]   imem_wdata,
    input  logic            dmem_we,
    input  logic [AW-1:0]   dmem_addr,
    input  logic [DW-1:0]   dmem_wdata,
    output logic [DW-1:0]   dmem_rdata,
    input  logic [RIDW-1:0] reg_sel,
    output logic [DW-1:0]   reg_rdata,
    output logic            halted,
    output logic            retire_valid,
    output logic [AW-1:0]   retire_pc
);
    core_st_t st_q, st_d;

    logic [IW-1:0]  fetch_word;
    logic [DW-1:0]  fo_reg_val;
    logic [DW-1:0]  fo_mem_val;

    logic           ex_flush, ex_wr_reg, ex_store;
    logic           haz_reg, haz_mem, stall, br_wait;
    op_e            dec_op;
    logic           dec_halt;
    logic [DW-1:0]  wb_data;

    logic           dm_we;
    logic [AW-1:0]  dm_waddr;
    logic [DW-1:0]  dm_wdata;

    // execute-segment decisions
    always_comb begin
        ex_flush  = st_q.o.v && (st_q.o.op == OP_BRA);
        ex_wr_reg = st_q.o.v && writes_reg(st_q.o.op);
        ex_store  = st_q.o.v && (st_q.o.op == OP_STO);
        wb_data   = (st_q.o.op == OP_LDI) ? st_q.o.ad[DW-1:0]
                                          : st_q.o.rv + st_q.o.mv;
        haz_reg   = st_q.d.v && reads_reg(st_q.d.op) && ex_wr_reg
                    && (st_q.d.rd == st_q.o.rd);
        haz_mem   = st_q.d.v && (st_q.d.op == OP_ADDM) && ex_store
                    && (st_q.d.ad == st_q.o.ad);
        stall     = haz_reg || haz_mem;
        br_wait   = st_q.d.v && (st_q.d.op == OP_BRA);
        dec_op    = decode_op(st_q.f.ir[IW-1 -: OPW]);
        dec_halt  = st_q.f.v && (dec_op == OP_HALT);
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (st_q.o.v && (st_q.o.op == OP_HALT)) begin
            st_d.halted = 1'b1;
        end
        if (ex_flush) begin
            st_d.pc  = st_q.o.ad;
            st_d.f.v = 1'b0;
            st_d.d.v = 1'b0;
            st_d.o.v = 1'b0;
        end else if (stall) begin
            st_d.o.v = 1'b0;
        end else begin
            st_d.o.v  = st_q.d.v;
            st_d.o.pc = st_q.d.pc;
            st_d.o.op = st_q.d.op;
            st_d.o.rd = st_q.d.rd;
            st_d.o.ad = st_q.d.ad;
            st_d.o.rv = fo_reg_val;
            st_d.o.mv = fo_mem_val;
            if (br_wait) begin
                st_d.d.v = 1'b0;
            end else begin
                st_d.d.v  = st_q.f.v;
                st_d.d.pc = st_q.f.pc;
                st_d.d.op = dec_op;
                st_d.d.rd = st_q.f.ir[AW +: RIDW];
                st_d.d.ad = st_q.f.ir[AW-1:0];
                if (dec_halt) begin
                    st_d.halt_seen = 1'b1;
                end
                if (st_q.halt_seen || dec_halt) begin
                    st_d.f.v = 1'b0;
                end else begin
                    st_d.f.v  = 1'b1;
                    st_d.f.pc = st_q.pc;
                    st_d.f.ir = fetch_word;
                    st_d.pc   = st_q.pc + AW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dm_we    = rst_n ? ex_store : dmem_we;
        dm_waddr = rst_n ? st_q.o.ad : dmem_addr;
        dm_wdata = rst_n ? st_q.o.rv : dmem_wdata;
    end

    pipe4_imem #(.AW(AW), .IW(IW)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (imem_we && !rst_n),
        .waddr (imem_addr),
        .wdata (imem_wdata),
        .raddr (st_q.pc),
        .rdata (fetch_word)
    );

    pipe4_dmem #(.AW(AW), .DW(DW)) u_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (dm_we),
        .waddr   (dm_waddr),
        .wdata   (dm_wdata),
        .ra_addr (st_q.d.ad),
        .ra_data (fo_mem_val),
        .rb_addr (dmem_addr),
        .rb_data (dmem_rdata)
    );

    pipe4_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ex_wr_reg),
        .wsel    (st_q.o.rd),
        .wdata   (wb_data),
        .ra_sel  (st_q.d.rd),
        .ra_data (fo_reg_val),
        .rb_sel  (reg_sel),
        .rb_data (reg_rdata)
    );

    assign halted       = st_q.halted;
    assign retire_valid = st_q.o.v;
    assign retire_pc    = st_q.o.pc;

    // R5: three empty execute cycles after a jump
    a_r5_jump_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ex_flush |=> !retire_valid ##1 !retire_valid ##1 !retire_valid);

    // R5: the instruction behind a decoded jump is held in fetch
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (br_wait && !ex_flush) |=> $stable(st_q.f));

    // R7: a conflict wait empties execute and holds operand fetch
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !retire_valid && $stable(st_q.d));

    // R9: halt is sticky and nothing executes after it
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !retire_valid);

endmodule

// File: tb/pipe4_core_bench.sv
`timescale 1ns/1ps
module pipe4_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [7:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [7:0]  dmem_addr = '0;
    logic [7:0]  dmem_wdata = '0;
    logic [7:0]  dmem_rdata;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_rdata;
    logic        halted, retire_valid;
    logic [7:0]  retire_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] prog [16];
    int dm_a [8];
    int dm_v [8];
    int dm_n;
    int exp_pc [16];
    int exp_cy [16];

    int cyc;
    int tr_n;
    int tr_pc [32];
    int tr_cy [32];

    always #5 clk = ~clk;

    pipe4_core u_pipe4_core (
        .clk(clk), .rst_n(rst_n),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
        .halted(halted), .retire_valid(retire_valid), .retire_pc(retire_pc)
    );

    // execute trace, sampled 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (!rst_n) begin
            cyc  = 0;
            tr_n = 0;
        end else begin
            cyc = cyc + 1;
            if (retire_valid && tr_n < 32) begin
                tr_pc[tr_n] = int'(retire_pc);
                tr_cy[tr_n] = cyc;
                tr_n = tr_n + 1;
            end
        end
    end

    function automatic logic [15:0] ins(input int op, input int r, input int a);
        return {op[3:0], r[3:0], a[7:0]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = '0;
        dm_n = 0;
    endtask

    task automatic add_dm(input int a, input int v);
        dm_a[dm_n] = a;
        dm_v[dm_n] = v;
        dm_n++;
    endtask

    task automatic run_prog(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            imem_we = 1'b1; imem_addr = 8'(i); imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        for (int i = 0; i < dm_n; i++) begin
            dmem_we = 1'b1; dmem_addr = 8'(dm_a[i]); dmem_wdata = 8'(dm_v[i]);
            @(negedge clk);
        end
        dmem_we = 1'b0;
        reg_sel = 4'd1;
        #1;
        chk("R1", "reset retire_valid", int'(retire_valid), 0);
        chk("R1", "reset halted", int'(halted), 0);
        chk("R1", "reset register", int'(reg_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 100 && !halted; k++) @(negedge clk);
        chk(req, "halted reached", int'(halted), 1);
        for (int k = 0; k < 4; k++) @(negedge clk);
    endtask

    task automatic chk_trace(input string req, input int n);
        chk(req, "trace length", tr_n, n);
        for (int i = 0; i < n && i < tr_n; i++) begin
            chk(req, "trace pc", tr_pc[i], exp_pc[i]);
            chk(req, "trace cycle", tr_cy[i], exp_cy[i]);
        end
    endtask

    task automatic chk_reg(input string req, input int r, input int v);
        @(negedge clk);
        reg_sel = 4'(r);
        #1;
        chk(req, "register", int'(reg_rdata), v);
    endtask

    task automatic chk_mem(input string req, input int a, input int v);
        @(negedge clk);
        dmem_addr = 8'(a);
        #1;
        chk(req, "memory", int'(dmem_rdata), v);
    endtask

    // straight-line code, R2 R3 R4 R9, then R10
    task automatic t_straight();
        clear_prog();
        prog[0] = ins(1, 1, 5);
        prog[1] = ins(1, 2, 7);
        prog[2] = ins(2, 1, 8'h10);
        prog[3] = ins(3, 2, 8'h20);
        prog[4] = ins(15, 0, 0);
        prog[5] = ins(1, 4, 99);
        add_dm(8'h10, 3);
        run_prog("R9");
        for (int i = 0; i < 5; i++) begin
            exp_pc[i] = i;
            exp_cy[i] = 3 + i;
        end
        chk_trace("R4", 5);
        chk_reg("R3", 1, 8);
        chk_reg("R3", 2, 7);
        chk_mem("R3", 8'h20, 7);
        chk_reg("R9", 4, 0);
        @(negedge clk);
        dmem_we = 1'b1; dmem_addr = 8'h20; dmem_wdata = 8'hAA;
        @(negedge clk);
        dmem_we = 1'b0;
        chk_mem("R10", 8'h20, 7);
    endtask

    // unused opcode behaves as nothing, R2
    task automatic t_nop_code();
        clear_prog();
        prog[0] = ins(1, 3, 11);
        prog[1] = ins(7, 3, 50);
        prog[2] = ins(15, 0, 0);
        run_prog("R2");
        chk_reg("R2", 3, 11);
    endtask

    // jump with shadow instruction, R5 R6
    task automatic t_branch();
        clear_prog();
        prog[0] = ins(1, 1, 1);
        prog[1] = ins(4, 0, 5);
        prog[2] = ins(1, 1, 9);
        prog[3] = ins(1, 2, 9);
        prog[4] = ins(15, 0, 0);
        prog[5] = ins(1, 3, 4);
        prog[6] = ins(15, 0, 0);
        run_prog("R5");
        exp_pc[0] = 0; exp_cy[0] = 3;
        exp_pc[1] = 1; exp_cy[1] = 4;
        exp_pc[2] = 5; exp_cy[2] = 8;
        exp_pc[3] = 6; exp_cy[3] = 9;
        chk_trace("R5", 4);
        chk_reg("R6", 1, 1);
        chk_reg("R5", 2, 0);
        chk_reg("R5", 3, 4);
    endtask

    // register conflict with wrap-around add, R7 R3
    task automatic t_reg_conflict();
        clear_prog();
        prog[0] = ins(1, 1, 200);
        prog[1] = ins(2, 1, 8'h10);
        prog[2] = ins(3, 1, 8'h11);
        prog[3] = ins(15, 0, 0);
        add_dm(8'h10, 100);
        run_prog("R7");
        exp_pc[0] = 0; exp_cy[0] = 3;
        exp_pc[1] = 1; exp_cy[1] = 5;
        exp_pc[2] = 2; exp_cy[2] = 7;
        exp_pc[3] = 3; exp_cy[3] = 8;
        chk_trace("R7", 4);
        chk_reg("R3", 1, 44);
        chk_mem("R7", 8'h11, 44);
    endtask

    // memory conflict, R8
    task automatic t_mem_conflict();
        clear_prog();
        prog[0] = ins(1, 2, 9);
        prog[1] = ins(3, 2, 8'h30);
        prog[2] = ins(2, 3, 8'h30);
        prog[3] = ins(15, 0, 0);
        add_dm(8'h30, 1);
        run_prog("R8");
        exp_pc[0] = 0; exp_cy[0] = 3;
        exp_pc[1] = 1; exp_cy[1] = 5;
        exp_pc[2] = 2; exp_cy[2] = 7;
        exp_pc[3] = 3; exp_cy[3] = 8;
        chk_trace("R8", 4);
        chk_reg("R8", 3, 9);
        chk_mem("R8", 8'h30, 9);
    endtask

    // conflict wait while a jump is in decode, R11
    task automatic t_wait_with_jump();
        clear_prog();
        prog[0] = ins(1, 1, 3);
        prog[1] = ins(3, 1, 8'h40);
        prog[2] = ins(4, 0, 6);
        prog[3] = ins(1, 2, 1);
        prog[4] = ins(15, 0, 0);
        prog[5] = ins(15, 0, 0);
        prog[6] = ins(1, 4, 2);
        prog[7] = ins(15, 0, 0);
        run_prog("R11");
        exp_pc[0] = 0; exp_cy[0] = 3;
        exp_pc[1] = 1; exp_cy[1] = 5;
        exp_pc[2] = 2; exp_cy[2] = 6;
        exp_pc[3] = 6; exp_cy[3] = 10;
        exp_pc[4] = 7; exp_cy[4] = 11;
        chk_trace("R11", 5);
        chk_reg("R11", 2, 0);
        chk_reg("R11", 4, 2);
        chk_mem("R11", 8'h40, 3);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_straight();
        t_nop_code();
        t_branch();
        t_reg_conflict();
        t_mem_conflict();
        t_wait_with_jump();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule